// File: doc/BRIEF.md
# Dual Level / Slope Alarm Monitor

This block watches two independent alarm channels over a stream of sensor samples. On every sample strobe each channel takes one of several 16-bit data words (the rate word, optionally its filtered variant, the temperature word, or the block's own status word) and tests it against a signed threshold. A channel either tests the level of the word or the change of the word since a programmable number of samples earlier, and its direction bit chooses "above" or "below". A channel whose test holds at a sample sets a sticky flag in the status word. Reading the status word clears both flags.

The flags also feed an alarm indicator that can drive either of two digital pins with a chosen polarity. Each pin is resolved by fixed priority: the data-ready pulse wins if it is routed there, then the alarm indicator, and otherwise the general-purpose direction and data bits. Pin values and enables are registered.

Top module: `alarm_monitor`

## Requirements
- R1: Source select per channel: 0 = channel off (never flags), 1 = rate word, 2 = temperature word, 3 = status word; codes 4 to 15 also turn the channel off. The status word is {6'b0, flag2, flag1, diag_low[7:0]}, taken before the current sample updates it.
- R2: In level mode (dyn = 0) a channel holds when the word, signed, is strictly greater than the signed threshold (gt = 1) or strictly less than it (gt = 0).
- R3: In slope mode (dyn = 1) the compared value is current word minus the word N samples earlier, formed as a 17-bit signed difference and compared strictly against the sign-extended threshold, with the same gt rule.
- R4: The 8-bit window N treats 0 and 1 alike: both mean one sample back.
- R5: A slope-mode channel cannot hold until N samples have been taken since reset or since its key (source, mode, window, and the filter bit while the source is 1) last changed.
- R6: The shared filter bit replaces the rate word with the filtered rate word for source 1 only; other sources ignore it.
- R7: Channel 1 sets status bit 8 and channel 2 sets bit 9 at the clock edge of a sample strobe whose test holds; flags stay set until read.
- R8: A status-read strobe clears both flags at that clock edge; a flag whose test holds at a sample strobe on the same edge ends set.
- R9: The alarm indicator is active when either flag is set; ind_pol = 1 drives it high when active, 0 drives it low; ind_line selects pin 0 or pin 1; ind_en claims the pin.
- R10: Per pin, priority is: data-ready (drdy_en and drdy_line select it, value drdy_lvl), then the alarm indicator, then gpio_dir/gpio_dat. Pins update one clock after their inputs.
- R11: After reset both flags are 0 and both pins have enable 0 and value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe, at least two cycles apart |
| rate_raw | input | 16 | Unfiltered rate word |
| rate_filt | input | 16 | Filtered rate word |
| temp_val | input | 16 | Temperature word |
| diag_low | input | 8 | Other status bits, low byte of the status word |
| a1_src | input | 4 | Channel 1 source select |
| a2_src | input | 4 | Channel 2 source select |
| a1_dyn | input | 1 | Channel 1 slope mode |
| a2_dyn | input | 1 | Channel 2 slope mode |
| a1_gt | input | 1 | Channel 1 direction, 1 = above |
| a2_gt | input | 1 | Channel 2 direction, 1 = above |
| a1_thr | input | 16 | Channel 1 signed threshold |
| a2_thr | input | 16 | Channel 2 signed threshold |
| a1_win | input | 8 | Channel 1 slope window N |
| a2_win | input | 8 | Channel 2 slope window N |
| filt_sel | input | 1 | Use filtered rate word |
| ind_en | input | 1 | Alarm indicator enable |
| ind_pol | input | 1 | Alarm indicator polarity, 1 = active high |
| ind_line | input | 1 | Alarm indicator pin select |
| stat_rd | input | 1 | Status-read strobe |
| drdy_en | input | 1 | Data-ready routing enable |
| drdy_line | input | 1 | Data-ready pin select |
| drdy_lvl | input | 1 | Data-ready signal level |
| gpio_dir | input | 2 | General-purpose direction per pin, 1 = drive |
| gpio_dat | input | 2 | General-purpose data per pin |
| flags | output | 2 | Sticky alarm flags {ch2, ch1} |
| stat_word | output | 16 | Status word |
| pin_out | output | 2 | Resolved pin values |
| pin_oe | output | 2 | Resolved pin drive enables |

## Verification
Directed level tests put words exactly on, one above and one below the threshold in both directions, which separates strict from inclusive and signed from unsigned comparison. Slope tests use ramps with windows of 0, 1 and larger values and check that nothing fires during the fill period, which tells a correct history offset and validity count from an off-by-one; a jump from 0x8000 to 0x7FFF separates a widened difference from a wrapped one. Filter and source tests change only the word that the current source ignores, and pin tests walk every routing combination so the priority order is pinned down. A seeded random phase then mixes configuration changes, reads coincident with samples and random words against a bench model.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW = 16;

  typedef enum logic [3:0] {
    SRC_OFF  = 4'd0,
    SRC_RATE = 4'd1,
    SRC_TEMP = 4'd2,
    SRC_STAT = 4'd3
  } src_e;

  // Chooses the word a channel watches; filter bit only matters for the rate word.
  function automatic logic [DW-1:0] pick_src(input logic [3:0] s, input logic filt,
                                             input logic [DW-1:0] raw, input logic [DW-1:0] fil,
                                             input logic [DW-1:0] temp, input logic [DW-1:0] stat);
    case (s)
      SRC_RATE: pick_src = filt ? fil : raw;
      SRC_TEMP: pick_src = temp;
      SRC_STAT: pick_src = stat;
      default:  pick_src = '0;
    endcase
  endfunction

  function automatic logic src_on(input logic [3:0] s);
    src_on = (s == SRC_RATE) || (s == SRC_TEMP) || (s == SRC_STAT);
  endfunction
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int DW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_stb,
  input  logic          en,
  input  logic [DW-1:0] val,
  input  logic          dyn,
  input  logic          gt,
  input  logic [WW-1:0] win,
  input  logic [DW-1:0] thr,
  input  logic          key_chg,
  output logic          hit
);
  localparam int DEPTH = 1 << WW;

  logic [DW-1:0] hist_mem [DEPTH];
  logic [DW-1:0] old_q;
  logic [WW-1:0] wp;
  logic [WW-1:0] cnt;
  logic [WW-1:0] n_eff;
  logic          valid;
  logic [DW:0]   diff;
  logic [DW:0]   thr_x;
  logic          lvl_hit;
  logic          slp_hit;

  assign n_eff = (win <= WW'(1)) ? WW'(1) : win;
  assign valid = (cnt >= n_eff);

  // History ring: synchronous write and registered read for block RAM.
  always_ff @(posedge clk) begin
    if (smp_stb) hist_mem[wp] <= val;
    old_q <= hist_mem[wp - n_eff];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (smp_stb) wp <= wp + WW'(1);
      if (key_chg) cnt <= '0;
      else if (smp_stb && cnt != {WW{1'b1}}) cnt <= cnt + WW'(1);
    end
  end

  assign diff    = {val[DW-1], val} - {old_q[DW-1], old_q};
  assign thr_x   = {thr[DW-1], thr};
  assign lvl_hit = gt ? ($signed(val) > $signed(thr)) : ($signed(val) < $signed(thr));
  assign slp_hit = valid && (gt ? ($signed(diff) > $signed(thr_x))
                                : ($signed(diff) < $signed(thr_x)));
  assign hit     = en && (dyn ? slp_hit : lvl_hit);

  // R5
  slope_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && dyn && (cnt < n_eff)) |-> !hit);
endmodule

// File: rtl/alarm_pin_mux.sv
module alarm_pin_mux #(
  parameter int NL = 2,
  parameter int LW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drdy_en,
  input  logic [LW-1:0] drdy_line,
  input  logic          drdy_lvl,
  input  logic          ind_en,
  input  logic [LW-1:0] ind_line,
  input  logic          ind_lvl,
  input  logic [NL-1:0] gpio_dir,
  input  logic [NL-1:0] gpio_dat,
  output logic [NL-1:0] pin_out,
  output logic [NL-1:0] pin_oe
);
  for (genvar j = 0; j < NL; j++) begin : g_line
    logic dr_own;
    logic ind_own;
    assign dr_own  = drdy_en && (drdy_line == LW'(j));
    assign ind_own = ind_en && (ind_line == LW'(j));

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[j] <= 1'b0;
        pin_oe[j]  <= 1'b0;
      end else if (dr_own) begin
        pin_out[j] <= drdy_lvl;
        pin_oe[j]  <= 1'b1;
      end else if (ind_own) begin
        pin_out[j] <= ind_lvl;
        pin_oe[j]  <= 1'b1;
      end else begin
        pin_out[j] <= gpio_dat[j];
        pin_oe[j]  <= gpio_dir[j];
      end
    end

    // R10
    drdy_first_chk: assert property (@(posedge clk) disable iff (rst)
      (drdy_en && drdy_line == LW'(j)) |=> (pin_oe[j] && pin_out[j] == $past(drdy_lvl)));

    // R9
    ind_route_chk: assert property (@(posedge clk) disable iff (rst)
      (!(drdy_en && drdy_line == LW'(j)) && ind_en && ind_line == LW'(j))
        |=> (pin_oe[j] && pin_out[j] == $past(ind_lvl)));
  end
endmodule

// File: rtl/alarm_monitor.sv
module alarm_monitor
  import alarm_pkg::*;
#(
  parameter int WW = 8,
  parameter int SW = 4,
  parameter int NL = 2,
  parameter int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_stb,
  input  logic [DW-1:0] rate_raw,
  input  logic [DW-1:0] rate_filt,
  input  logic [DW-1:0] temp_val,
  input  logic [7:0]    diag_low,
  input  logic [SW-1:0] a1_src,
  input  logic [SW-1:0] a2_src,
  input  logic          a1_dyn,
  input  logic          a2_dyn,
  input  logic          a1_gt,
  input  logic          a2_gt,
  input  logic [DW-1:0] a1_thr,
  input  logic [DW-1:0] a2_thr,
  input  logic [WW-1:0] a1_win,
  input  logic [WW-1:0] a2_win,
  input  logic          filt_sel,
  input  logic          ind_en,
  input  logic          ind_pol,
  input  logic [LW-1:0] ind_line,
  input  logic          stat_rd,
  input  logic          drdy_en,
  input  logic [LW-1:0] drdy_line,
  input  logic          drdy_lvl,
  input  logic [NL-1:0] gpio_dir,
  input  logic [NL-1:0] gpio_dat,
  output logic [1:0]    flags,
  output logic [DW-1:0] stat_word,
  output logic [NL-1:0] pin_out,
  output logic [NL-1:0] pin_oe
);
  localparam int KW = SW + WW + 2;

  logic [1:0] hit;
  logic       ind_lvl;

  assign stat_word = {{(DW-10){1'b0}}, flags, diag_low};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SW-1:0] src;
    logic          dyn;
    logic [WW-1:0] win;
    logic [KW-1:0] key;
    logic [KW-1:0] key_q;
    logic          key_chg;
    logic [DW-1:0] val;

    assign src = (c == 0) ? a1_src : a2_src;
    assign dyn = (c == 0) ? a1_dyn : a2_dyn;
    assign win = (c == 0) ? a1_win : a2_win;
    assign key = {src, dyn, win, (src == SW'(SRC_RATE)) && filt_sel};
    assign key_chg = (key != key_q);
    assign val = pick_src(4'(src), filt_sel, rate_raw, rate_filt, temp_val, stat_word);

    always_ff @(posedge clk) begin
      if (rst) key_q <= key;
      else     key_q <= key;
    end

    alarm_channel #(.DW(DW), .WW(WW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .smp_stb (smp_stb),
      .en      (src_on(4'(src))),
      .val     (val),
      .dyn     (dyn),
      .gt      ((c == 0) ? a1_gt : a2_gt),
      .win     (win),
      .thr     ((c == 0) ? a1_thr : a2_thr),
      .key_chg (key_chg && !rst),
      .hit     (hit[c])
    );

    always_ff @(posedge clk) begin
      if (rst)                     flags[c] <= 1'b0;
      else if (smp_stb && hit[c])  flags[c] <= 1'b1;
      else if (stat_rd)            flags[c] <= 1'b0;
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[c]) |-> $past(smp_stb));
  end

  assign ind_lvl = ind_pol ? (|flags) : !(|flags);

  alarm_pin_mux #(.NL(NL), .LW(LW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .drdy_en   (drdy_en),
    .drdy_line (drdy_line),
    .drdy_lvl  (drdy_lvl),
    .ind_en    (ind_en),
    .ind_line  (ind_line),
    .ind_lvl   (ind_lvl),
    .gpio_dir  (gpio_dir),
    .gpio_dat  (gpio_dat),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !smp_stb) |=> (flags == 2'b00));
endmodule

// File: tb/alarm_monitor_bench.sv
module alarm_monitor_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic [15:0] rate_raw = '0, rate_filt = '0, temp_val = '0;
  logic [7:0]  diag_low = 8'h5A;
  logic [3:0]  src [2];
  logic        dyn [2];
  logic        gt  [2];
  logic [15:0] thr [2];
  logic [7:0]  win [2];
  logic filt_sel = 1'b0, ind_en = 1'b0, ind_pol = 1'b0, ind_line = 1'b0;
  logic stat_rd = 1'b0, drdy_en = 1'b0, drdy_line = 1'b0, drdy_lvl = 1'b0;
  logic [1:0] gpio_dir = '0, gpio_dat = '0;
  logic [1:0]  flags;
  logic [15:0] stat_word;
  logic [1:0]  pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_hist [2][256];
  int          m_wp = 0;
  int          m_cnt [2];
  logic [13:0] m_key [2];
  logic        m_flag [2];

  always #2.5 clk = ~clk;

  alarm_monitor u_alarm_monitor (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .rate_raw(rate_raw), .rate_filt(rate_filt), .temp_val(temp_val), .diag_low(diag_low),
    .a1_src(src[0]), .a2_src(src[1]), .a1_dyn(dyn[0]), .a2_dyn(dyn[1]),
    .a1_gt(gt[0]), .a2_gt(gt[1]), .a1_thr(thr[0]), .a2_thr(thr[1]),
    .a1_win(win[0]), .a2_win(win[1]), .filt_sel(filt_sel),
    .ind_en(ind_en), .ind_pol(ind_pol), .ind_line(ind_line), .stat_rd(stat_rd),
    .drdy_en(drdy_en), .drdy_line(drdy_line), .drdy_lvl(drdy_lvl),
    .gpio_dir(gpio_dir), .gpio_dat(gpio_dat),
    .flags(flags), .stat_word(stat_word), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] key_of(input int c);
    return {src[c], dyn[c], win[c], (src[c] == 4'd1) && filt_sel};
  endfunction

  // R1 R6: source word picked by the model
  function automatic logic [15:0] pick(input int c, input logic [15:0] r, input logic [15:0] f,
                                       input logic [15:0] t, input logic [15:0] sw);
    case (src[c])
      4'd1: return filt_sel ? f : r;
      4'd2: return t;
      4'd3: return sw;
      default: return 16'h0;
    endcase
  endfunction

  // R9 R10: expected {oe, out} per pin
  function automatic logic [3:0] exp_pins();
    logic [1:0] oe, ov;
    logic act;
    act = m_flag[0] | m_flag[1];
    for (int j = 0; j < 2; j++) begin
      if (drdy_en && drdy_line == j[0]) begin oe[j] = 1'b1; ov[j] = drdy_lvl; end
      else if (ind_en && ind_line == j[0]) begin oe[j] = 1'b1; ov[j] = ind_pol ? act : !act; end
      else begin oe[j] = gpio_dir[j]; ov[j] = gpio_dat[j]; end
    end
    return {oe, ov};
  endfunction

  task automatic sync_keys();
    for (int c = 0; c < 2; c++) begin
      if (key_of(c) != m_key[c]) begin m_cnt[c] = 0; m_key[c] = key_of(c); end
    end
  endtask

  task automatic set_ch(input int c, input logic [3:0] s, input logic d, input logic g,
                        input logic [15:0] th, input logic [7:0] w);
    @(negedge clk);
    src[c] = s; dyn[c] = d; gt[c] = g; thr[c] = th; win[c] = w;
    sync_keys();
  endtask

  task automatic set_filt(input logic f);
    @(negedge clk);
    filt_sel = f;
    sync_keys();
  endtask

  task automatic check_pins(input string req);
    logic [3:0] e;
    e = exp_pins();
    chk({pin_oe, pin_out} == e, req, {pin_oe, pin_out}, e);
  endtask

  task automatic sample(input logic [15:0] r, input logic [15:0] f, input logic [15:0] t,
                        input logic rd, input string req);
    logic [15:0] sw, v [2];
    logic        h [2];
    int          n;
    logic signed [16:0] d;
    sw = {6'b0, m_flag[1], m_flag[0], diag_low};
    for (int c = 0; c < 2; c++) begin
      v[c] = pick(c, r, f, t, sw);
      n = (win[c] <= 8'd1) ? 1 : int'(win[c]);
      h[c] = 1'b0;
      if (src[c] >= 4'd1 && src[c] <= 4'd3) begin
        if (!dyn[c])
          h[c] = gt[c] ? ($signed(v[c]) > $signed(thr[c])) : ($signed(v[c]) < $signed(thr[c]));
        else if (m_cnt[c] >= n) begin
          d = $signed({v[c][15], v[c]}) - $signed({m_hist[c][(m_wp - n) & 255][15], m_hist[c][(m_wp - n) & 255]});
          h[c] = gt[c] ? (d > $signed({thr[c][15], thr[c]})) : (d < $signed({thr[c][15], thr[c]}));
        end
      end
    end
    @(negedge clk);
    rate_raw = r; rate_filt = f; temp_val = t; smp_stb = 1'b1; stat_rd = rd;
    @(negedge clk);
    smp_stb = 1'b0; stat_rd = 1'b0;
    for (int c = 0; c < 2; c++) begin
      m_hist[c][m_wp] = v[c];
      if (m_cnt[c] < 255) m_cnt[c]++;
      m_flag[c] = (rd ? 1'b0 : m_flag[c]) | h[c];
    end
    m_wp = (m_wp + 1) & 255;
    chk(flags == {m_flag[1], m_flag[0]}, req, flags, {m_flag[1], m_flag[0]});
    @(negedge clk);
    check_pins("R9 R10 pins after sample");
  endtask

  task automatic read_status();
    @(negedge clk);
    stat_rd = 1'b1;
    chk(stat_word == {6'b0, m_flag[1], m_flag[0], diag_low}, "R7 status word", stat_word,
        {6'b0, m_flag[1], m_flag[0], diag_low});
    @(negedge clk);
    stat_rd = 1'b0;
    m_flag[0] = 1'b0; m_flag[1] = 1'b0;
    chk(flags == 2'b00, "R8 clear on read", flags, 0);
    @(negedge clk);
    check_pins("R9 pins after read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] base;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      src[c] = 4'd0; dyn[c] = 1'b0; gt[c] = 1'b0; thr[c] = '0; win[c] = '0;
      m_cnt[c] = 0; m_flag[c] = 1'b0; m_key[c] = key_of(c);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(flags == 2'b00, "R11 flags after reset", flags, 0);
    chk(pin_oe == 2'b00, "R11 pin enables after reset", pin_oe, 0);
    chk(pin_out == 2'b00, "R11 pin values after reset", pin_out, 0);

    // R2 level mode, strict, signed
    ind_en = 1'b1; ind_pol = 1'b1; ind_line = 1'b1;
    set_ch(0, 4'd1, 1'b0, 1'b1, 16'd100, 8'd0);
    sample(16'd100, 16'd0, 16'd0, 1'b0, "R2 equal is not above");
    sample(16'd101, 16'd0, 16'd0, 1'b0, "R2 above fires, R7 bit 8");
    sample(16'd0, 16'd0, 16'd0, 1'b0, "R7 sticky");
    read_status();
    set_ch(0, 4'd0, 1'b0, 1'b0, 16'd0, 8'd0);
    set_ch(1, 4'd2, 1'b0, 1'b0, 16'hFFFB, 8'd0);
    sample(16'd0, 16'd0, 16'hFFFB, 1'b0, "R2 equal is not below");
    sample(16'd0, 16'd0, 16'h7000, 1'b0, "R2 signed below");
    sample(16'd0, 16'd0, 16'hFFFA, 1'b0, "R2 below fires, R7 bit 9");
    // R8 read coincident with a holding sample
    sample(16'd0, 16'd0, 16'hFFFA, 1'b1, "R8 set wins over read");
    sample(16'd0, 16'd0, 16'd0, 1'b1, "R8 read clears");

    // R1 disabled codes
    set_ch(1, 4'd0, 1'b0, 1'b0, 16'h7FFF, 8'd0);
    sample(16'h8000, 16'h8000, 16'h8000, 1'b0, "R1 source 0 off");
    set_ch(1, 4'd9, 1'b0, 1'b0, 16'h7FFF, 8'd0);
    sample(16'h8000, 16'h8000, 16'h8000, 1'b0, "R1 source 9 off");

    // R6 filter bit
    set_ch(0, 4'd1, 1'b0, 1'b1, 16'd0, 8'd0);
    set_filt(1'b1);
    sample(16'd500, 16'hFE0C, 16'd0, 1'b0, "R6 filtered rate used");
    set_filt(1'b0);
    sample(16'd500, 16'hFE0C, 16'd0, 1'b0, "R6 raw rate used");
    read_status();
    set_ch(0, 4'd2, 1'b0, 1'b1, 16'd10, 8'd0);
    set_filt(1'b1);
    sample(16'd0, 16'd99, 16'd20, 1'b0, "R6 temperature ignores filter bit");
    read_status();

    // R1 status word as source: diag_low 0x5A, flags clear
    set_ch(0, 4'd3, 1'b0, 1'b1, 16'h0059, 8'd0);
    sample(16'd0, 16'd0, 16'd0, 1'b0, "R1 status word source");
    set_ch(1, 4'd3, 1'b0, 1'b1, 16'h0159, 8'd0);
    sample(16'd0, 16'd0, 16'd0, 1'b0, "R1 status word with bit 8 set");
    read_status();
    set_ch(0, 4'd0, 1'b0, 1'b0, 16'd0, 8'd0);
    set_ch(1, 4'd0, 1'b0, 1'b0, 16'd0, 8'd0);
    read_status();

    // R4 R5 slope window 0 and 1, fill period
    set_filt(1'b0);
    set_ch(0, 4'd1, 1'b1, 1'b1, 16'd10, 8'd0);
    sample(16'h4000, 16'd0, 16'd0, 1'b0, "R5 first sample after change cannot fire");
    sample(16'h4000 + 16'd11, 16'd0, 16'd0, 1'b0, "R4 window 0 is one back");
    read_status();
    set_ch(0, 4'd1, 1'b1, 1'b1, 16'd10, 8'd1);
    sample(16'h0100, 16'd0, 16'd0, 1'b0, "R5 refill after window change");
    sample(16'h0100 + 16'd10, 16'd0, 16'd0, 1'b0, "R3 strict slope");
    sample(16'h0100 + 16'd21, 16'd0, 16'd0, 1'b0, "R4 window 1 is one back");
    read_status();
    set_ch(0, 4'd1, 1'b1, 1'b1, 16'd10, 8'd4);
    for (int i = 0; i < 8; i++)
      sample(16'(i * 5), 16'd0, 16'd0, 1'b0, "R5 window 4 ramp");
    read_status();
    // R3 widened difference: 0x7FFF minus 0x8000 is +65535
    set_ch(0, 4'd1, 1'b1, 1'b1, 16'd0, 8'd1);
    sample(16'h8000, 16'd0, 16'd0, 1'b0, "R3 seed");
    sample(16'h7FFF, 16'd0, 16'd0, 1'b0, "R3 no wrap on difference");
    read_status();
    set_ch(1, 4'd2, 1'b1, 1'b0, 16'hFFF0, 8'd2);
    sample(16'd0, 16'd0, 16'd100, 1'b0, "R3 falling slope fill");
    sample(16'd0, 16'd0, 16'd90, 1'b0, "R5 not filled yet");
    sample(16'd0, 16'd0, 16'd60, 1'b0, "R3 drop of 40 over two");
    read_status();

    // R9 R10 pin priority walk
    set_ch(0, 4'd1, 1'b0, 1'b1, 16'd0, 8'd0);
    set_ch(1, 4'd0, 1'b0, 1'b0, 16'd0, 8'd0);
    sample(16'd5, 16'd0, 16'd0, 1'b0, "R9 raise indicator");
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      {drdy_en, drdy_line, drdy_lvl, ind_en, ind_pol, ind_line} = 6'(k);
      gpio_dir = 2'(k * 3); gpio_dat = 2'(k * 5);
      @(negedge clk);
      check_pins("R10 priority walk");
    end
    read_status();

    // Seeded random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) == 0) begin
        int c;
        logic [7:0] wsel [4];
        wsel[0] = 8'd0; wsel[1] = 8'd1; wsel[2] = 8'd3; wsel[3] = 8'd6;
        c = $urandom_range(0, 1);
        set_ch(c, 4'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               16'($signed($urandom_range(0, 400)) - 200), wsel[$urandom_range(0, 3)]);
      end
      if ($urandom_range(0, 19) == 0) set_filt(1'($urandom_range(0, 1)));
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk);
        {drdy_en, drdy_line, drdy_lvl, ind_en, ind_pol, ind_line} = 6'($urandom);
        gpio_dir = 2'($urandom); gpio_dat = 2'($urandom);
      end
      base = 16'($signed($urandom_range(0, 600)) - 300);
      sample(base, 16'($signed($urandom_range(0, 600)) - 300), 16'($urandom_range(0, 80)) - 16'd40,
             ($urandom_range(0, 4) == 0), "R3 R7 random sample");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule